// File: doc/BRIEF.md
# One-Hot Sequenced Successive-Approximation Controller

This block is the digital half of a successive-approximation converter: it holds the code that drives the switches of a charge-redistribution DAC, and it runs the binary search that finds that code. A single 1 in a sequencer register walks from the most significant position to the least significant one, one position per rising edge of the converter clock. Each position sets its trial bit. During the low phase of the clock the comparator result is latched. On the next rising edge that result decides whether the bit just tried is kept.

Once a conversion ends, the same data register becomes one stage of a serial chain that links many converters. In that mode it takes its serial input from the previous converter and shifts out most significant bit first. The chain output passes through one flop clocked on the falling edge. This half-cycle retiming keeps adjacent converters clear of hold problems. The comparator and the capacitor array are outside the block.

Top module: `sar_onehot_ctrl`

## Requirements
- R1: A rising edge that samples `start` high clears the code register and sets only its most significant bit as the first trial, so `dac_code` = 1 << (N-1). It also raises `busy`. `start` has priority over every other activity, including a conversion already in progress.
- R2: Edge j after the start edge (j = 1 .. N-1) tries bit position N-1-j, so trials run from the MSB to the LSB. After that edge, `dac_code` has bits above the trial position resolved, the trial bit at 1, and all lower bits at 0.
- R3: The comparator input is sampled only on the falling clock edge. Its value around the rising edge has no effect on the result.
- R4: A tried bit is kept when the latched comparator value is 1 (analog input at least the trial code) and cleared when it is 0. After a complete conversion, `dac_code` equals the largest code not above the input.
- R5: `done` rises on exactly the Nth edge after the start edge, one extra edge after the LSB trial that resolves the LSB. `busy` falls on that same edge. `done` stays low in between and is cleared by a new `start`.
- R6: While idle, with neither `shift_en` nor `start` active, `dac_code` and `done` hold their values.
- R7: While idle with `shift_en` high, each rising edge shifts the code one place toward the MSB and loads `chain_in` into the LSB. After N shifts of a word fed MSB first, `dac_code` equals that word.
- R8: `chain_out` is the code MSB, captured on each falling edge. The serial stream is therefore the held result MSB first, followed by the bits shifted in.
- R9: `shift_en` and `chain_in` are ignored while a conversion runs.
- R10: After reset, `dac_code` is 0, `busy` and `done` are low, and `chain_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; rising edge advances, falling edge samples comparator and retimes chain output |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion (restarts one in progress) |
| cmp_in | input | 1 | Comparator decision, 1 when input is at least the trial code |
| shift_en | input | 1 | Select serial shift mode while idle |
| chain_in | input | 1 | Serial data from the previous converter in the chain |
| dac_code | output | N | Code register, drives the DAC switches |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result resolved and held |
| chain_out | output | 1 | Falling-edge retimed serial output to the next converter |

## Verification
The first trial code is due on the rising edge that samples `start`. Each later trial appears one edge after the previous one. The final code and the rise of `done` come N edges after the start edge. Each shift moves the register on the edge that samples `shift_en`. `chain_out` follows half a cycle later, on the falling edge. The bench drives inputs just after a rising edge and reads outputs just after the following falling edge, so every code and flag is checked on the edge it is due. The comparator model inverts its answer in a window around each rising edge, so a result only comes out right if the comparator is sampled on the falling edge.

// File: rtl/sar_pkg.sv
// Shared definitions for the successive-approximation controller.
// Assumes nothing beyond a single converter clock.
package sar_pkg;

    // Default resolution of the converter code.
    localparam int SAR_BITS_DEFAULT = 10;

    // Operating mode of the code register, chosen by the top level.
    typedef enum logic [1:0] {
        REG_HOLD    = 2'd0,
        REG_CONVERT = 2'd1,
        REG_SHIFT   = 2'd2
    } sar_mode_t;

endpackage

// File: rtl/sar_seq.sv
// One-hot trial sequencer. A start loads a single 1 into the MSB position.
// Each later rising edge moves it one place toward the LSB until it falls
// off the end. The edge on which it leaves the LSB raises done.
// Assumes start is a synchronous level sampled on the rising edge.
module sar_seq #(
    parameter int N = sar_pkg::SAR_BITS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [N-1:0] seq,
    output logic         busy,
    output logic         done
);

    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] seq_q;
    logic         done_q;

    // Walk the single 1 from MSB to LSB, one position per edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      seq_q <= '0;
        else if (start)  seq_q <= MSB_ONLY;
        else             seq_q <= seq_q >> 1;
    end

    // Raise done when the LSB trial has been resolved; clear on start.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_q <= 1'b0;
        else if (start)     done_q <= 1'b0;
        else if (seq_q[0])  done_q <= 1'b1;
    end

    assign seq  = seq_q;
    assign busy = |seq_q;
    assign done = done_q;

    // R2: never more than one trial position active.
    assert_seq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_q));

    // R2: the active position moves exactly one place per edge.
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (seq_q == ($past(seq_q) >> 1)));

    // R1: a start places the trial at the MSB.
    assert_seq_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (seq_q == MSB_ONLY));

    // R5: done only rises after the LSB trial was active.
    assert_done_after_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(seq_q[0]));

endmodule

// File: rtl/sar_cmp_latch.sv
// Comparator decision latch. Samples the comparator on the falling edge of
// the converter clock while a conversion runs, so the decision is settled
// by the next rising edge. Assumes the comparator is valid at that edge.
module sar_cmp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_in,
    output logic cmp_q
);

    logic dec_q;

    // Capture the comparator during the low phase of the clock.
    always_ff @(negedge clk) begin
        if (!rst_n)   dec_q <= 1'b0;
        else if (en)  dec_q <= cmp_in;
    end

    assign cmp_q = dec_q;

    // R3: outside a conversion the latched decision does not move.
    assert_latch_hold_R3: assert property (@(negedge clk) disable iff (!rst_n)
        !en |=> $stable(dec_q));

endmodule

// File: rtl/sar_data_reg.sv
// Code register. In convert mode, bit k takes the latched decision while
// it is the active trial, and is set to 1 when the trial above it is
// resolved. In shift mode the register moves toward the MSB with chain_in
// entering the LSB. A start overrides both and loads the MSB trial.
// Assumes seq is one-hot or zero whenever mode is REG_CONVERT.
module sar_data_reg #(
    parameter int N = sar_pkg::SAR_BITS_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  sar_pkg::sar_mode_t  mode,
    input  logic [N-1:0]        seq,
    input  logic                cmp_q,
    input  logic                chain_in,
    output logic [N-1:0]        data
);

    import sar_pkg::*;

    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] ONE      = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] set_trial;
    logic [N-1:0] shift_src;

    // Bit k becomes the trial when the position above it is resolved.
    assign set_trial = {1'b0, seq[N-1:1]};
    // Serial path: each bit takes its lower neighbour, LSB takes chain_in.
    assign shift_src = {data[N-2:0], chain_in};

    for (genvar k = 0; k < N; k++) begin : g_bit
        localparam logic IS_MSB = (k == N - 1);
        logic bit_q;

        // Per-bit update: start, trial/resolve, or shift.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (start) begin
                bit_q <= IS_MSB;
            end else begin
                case (mode)
                    REG_CONVERT: begin
                        if (seq[k])             bit_q <= cmp_q;
                        else if (set_trial[k])  bit_q <= 1'b1;
                    end
                    REG_SHIFT:   bit_q <= shift_src[k];
                    default:     bit_q <= bit_q;
                endcase
            end
        end

        assign data[k] = bit_q;
    end

    // R1: start leaves only the MSB trial set.
    assert_start_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (data == MSB_ONLY));

    // R2: during a conversion no bit below the active trial is set.
    assert_low_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq) |-> ((data & (seq - ONE)) == '0));

    // R6: idle register holds.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REG_HOLD && !start) |=> $stable(data));

    // R7: shift moves toward the MSB and loads chain_in at the LSB.
    assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REG_SHIFT && !start) |=>
            (data == {$past(data[N-2:0]), $past(chain_in)}));

endmodule

// File: rtl/sar_chain_retime.sv
// Half-cycle retiming flop at the end of the serial chain. It samples the
// register MSB on the falling edge, so the next converter, which shifts
// on the rising edge, sees a value that changed half a cycle earlier.
module sar_chain_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    output logic chain_out
);

    logic out_q;

    // Retime the serial tap on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)  out_q <= 1'b0;
        else         out_q <= tap;
    end

    assign chain_out = out_q;

endmodule

// File: rtl/sar_onehot_ctrl.sv
// Successive-approximation controller top. It ties the one-hot sequencer,
// the comparator latch, the code register and the chain retiming flop
// together. The register mode is chosen here: convert while the sequencer
// is active, otherwise shift if requested, otherwise hold. This gates the
// shift path off during a conversion. Assumes one converter clock that
// drives both edges.
module sar_onehot_ctrl #(
    parameter int N = sar_pkg::SAR_BITS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_in,
    input  logic         shift_en,
    input  logic         chain_in,
    output logic [N-1:0] dac_code,
    output logic         busy,
    output logic         done,
    output logic         chain_out
);

    import sar_pkg::*;

    logic [N-1:0] seq;
    logic         cmp_q;
    logic         busy_w;
    sar_mode_t    mode;

    // Pick the register mode; conversion has priority over shifting.
    always_comb begin
        if (busy_w)         mode = REG_CONVERT;
        else if (shift_en)  mode = REG_SHIFT;
        else                mode = REG_HOLD;
    end

    sar_seq #(.N(N)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .seq   (seq),
        .busy  (busy_w),
        .done  (done)
    );

    sar_cmp_latch u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (busy_w),
        .cmp_in (cmp_in),
        .cmp_q  (cmp_q)
    );

    sar_data_reg #(.N(N)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .seq      (seq),
        .cmp_q    (cmp_q),
        .chain_in (chain_in),
        .data     (dac_code)
    );

    sar_chain_retime u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap       (dac_code[N-1]),
        .chain_out (chain_out)
    );

    assign busy = busy_w;

    // R8: at each rising edge the chain output equals the code MSB held since the last falling edge.
    assert_chain_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out == dac_code[N-1]);

    // R9: during a conversion the shift path cannot reach the register.
    assert_no_shift_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> (mode == REG_CONVERT));

endmodule

// File: tb/sim_sar_onehot_ctrl.sv
module sim_sar_onehot_ctrl;

    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         shift_en = 1'b0;
    logic         chain_in = 1'b0;
    logic         noisy = 1'b0;
    logic [N-1:0] vin = '0;
    logic         cmp_in;
    logic [N-1:0] dac_code;
    logic         busy;
    logic         done;
    logic         chain_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    // Behavioural comparator; gives the wrong answer around each rising edge (R3).
    assign cmp_in = noisy ^ (dac_code <= vin);

    always begin
        @(negedge clk);
        #2 noisy = 1'b1;
        #4 noisy = 1'b0;
    end

    sar_onehot_ctrl #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_in    (cmp_in),
        .shift_en  (shift_en),
        .chain_in  (chain_in),
        .dac_code  (dac_code),
        .busy      (busy),
        .done      (done),
        .chain_out (chain_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected code after edge j of a conversion of v (R2).
    function automatic int trial_code(input int v, input int j);
        int pos = N - 1 - j;
        return ((v >> (pos + 1)) << (pos + 1)) | (1 << pos);
    endfunction

    // Binary-search reference for the final code (R4).
    function automatic int ref_code(input int v);
        int c = 0;
        for (int b = N - 1; b >= 0; b--)
            if ((c | (1 << b)) <= v) c = c | (1 << b);
        return c;
    endfunction

    task automatic to_sample;
        @(negedge clk); #1;
    endtask

    // Full conversion; optional per-step checks and chain noise during it.
    task automatic run_conv(input int v, input bit steps, input bit chain_noise);
        vin = N'(v);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        to_sample();
        chk("R1 first trial code", dac_code, 1 << (N - 1));
        chk("R1 busy after start", busy, 1);
        for (int j = 1; j <= N; j++) begin
            @(posedge clk); #1;
            if (chain_noise) chain_in = 1'($urandom % 2);
            to_sample();
            if (j < N) begin
                if (steps) chk("R2 trial step code", dac_code, trial_code(v, j));
                if (steps) chk("R5 done low mid-conversion", done, 0);
            end else begin
                chk("R5 done on Nth edge", done, 1);
                chk("R5 busy low at end", busy, 0);
                chk("R4 final code", dac_code, ref_code(v));
            end
        end
    endtask

    initial begin
        int v;
        int w;
        int r;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        to_sample();
        chk("R10 reset code", dac_code, 0);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset chain_out", chain_out, 0);

        // Directed corners, then random inputs (R2, R3, R4, R5).
        run_conv(0, 1'b1, 1'b0);
        run_conv((1 << N) - 1, 1'b1, 1'b0);
        run_conv(1 << (N - 1), 1'b1, 1'b0);
        run_conv((1 << (N - 1)) - 1, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            v = int'($urandom % (1 << N));
            run_conv(v, 1'b1, 1'b0);
        end

        // R6: idle hold.
        r = int'(dac_code);
        repeat (5) @(posedge clk);
        to_sample();
        chk("R6 idle code held", dac_code, r);
        chk("R6 idle done held", done, 1);

        // R9: shift request and chain noise during a conversion.
        shift_en = 1'b1;
        v = int'($urandom % (1 << N));
        run_conv(v, 1'b0, 1'b1);
        shift_en = 1'b0;

        // R10-style restart: R1 start wins over a running conversion.
        vin = N'(37);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (4) @(posedge clk);
        to_sample();
        chk("R1 still busy before restart", busy, 1);
        run_conv(812, 1'b1, 1'b0);

        // R7/R8: shift the result out and a word in, several patterns.
        for (int t = 0; t < 4; t++) begin
            v = (t == 0) ? 10'h2AA : int'($urandom % (1 << N));
            run_conv(v, 1'b0, 1'b0);
            r = int'(dac_code);
            w = (t == 1) ? 10'h3FF : int'($urandom % (1 << N));
            shift_en = 1'b1;
            for (int i = 0; i < N; i++) begin
                chain_in = 1'((w >> (N - 1 - i)) & 1);
                chk("R8 chain_out result bit", chain_out, (r >> (N - 1 - i)) & 1);
                @(posedge clk); #1;
                to_sample();
            end
            shift_en = 1'b0;
            chk("R7 shifted-in word", dac_code, w);
            chk("R8 chain_out first fed bit", chain_out, (w >> (N - 1)) & 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule